// File: doc/BRIEF.md
# Multi-Channel Interval Timer

A register-mapped timer block holding several independent up-counting channels (six by default, numbered 1 upward). Each channel counts ticks from one of two tick-enable inputs, a fast system tick or a slow 32 kHz tick. The selected tick can optionally be divided by two. A channel runs in one of three modes: single-shot, auto-reload or free-running. When its counter reaches the programmed compare value, the channel raises a pending flag.

Software programs the block through a single-cycle synchronous register bus. A write takes effect at the clock edge on which `bus_wr` is high. Read data is a combinational function of `bus_addr` and the current state. A shared enable register and a shared acknowledge register gate the pending flags onto one interrupt line.

Top module: `tmr_multi`

## Requirements
- R1: Address map. The interrupt-enable register is at 0x00 and the acknowledge register is at 0x08; channel n uses bit n-1 in both. Channel n occupies the 16-byte window at 0x10*n: control at +0x0, clock select at +0x4, count at +0x8 (read-only), compare at +0xC. Unmapped addresses read 0. The control register reads back {mode in bits 5:4, run in bit 0}. The clock-select register reads back {source in bit 4, divider in bit 0}. The compare register reads back as written.
- R2: Control bit 0 is the run bit. While it is 0, ticks leave the count unchanged. While it is 1, each qualifying tick advances the count by one.
- R3: Writing control bit 1 = 1 zeroes the count and the divide phase. The bit always reads back 0. A control write takes priority over a tick arriving in the same cycle, so that tick is not counted.
- R4: Clock-select bit 4 picks the tick: 0 selects `tick_fast` and 1 selects `tick_slow`. Ticks on the other input are ignored.
- R5: Clock-select bit 0 = 1 counts only every second selected tick, starting with the second tick after a clear. Bit 0 = 0 counts every selected tick.
- R6: Mode 1 (auto-reload): the counted tick that makes the count equal the compare value sets the pending flag. The next counted tick returns the count to 0.
- R7: Mode 0 (single-shot): the counted tick that makes the count equal the compare value sets the pending flag and clears the run bit. The count then holds at the compare value.
- R8: Mode 3 (free-running) and reserved mode 2 set the pending flag on a match but keep counting. The count wraps to 0 after 2^CNT_W - 1.
- R9: Writing 1 to an acknowledge bit clears that pending flag, and writing 0 leaves it unchanged. Writing 0x3f clears all six flags. Reading 0x08 returns the raw pending bits. A match in the same cycle as its acknowledge leaves the flag set.
- R10: `irq` is high exactly when some channel has both its pending flag and its enable bit set.
- R11: After reset, all registers, counts and pending flags are 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (8) | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| tick_fast | input | 1 | System tick enable |
| tick_slow | input | 1 | 32 kHz tick enable |
| irq | output | 1 | Combined interrupt |

## Verification
The bench drives each mode with a different tick pattern. The single-shot channel gets more ticks than its compare value, which separates stopping from wrapping. The auto-reload channel is stepped one tick at a time around its compare value, which pins the cycle in which the count returns to zero. The free-running channel gets enough ticks to pass both the match and the full wrap.

Bursts on the unselected tick input, together with a divided slow tick, separate the source choice from the divider. A clear write on a tick cycle shows which of the two wins. An acknowledge on a match cycle shows which of the two wins.

A behavioural reference model tracks every register. It checks the interrupt line on every cycle and each register read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    MODE_ONCE = 2'd0,
    MODE_LOOP = 2'd1,
    MODE_RSVD = 2'd2,
    MODE_FREE = 2'd3
  } tmr_mode_e;

  // Next count on a counted tick: auto-reload returns to zero from the
  // compare value, every other case increments and wraps within mask.
  function automatic logic [DATA_W-1:0] tmr_next(
    input logic [DATA_W-1:0] cnt,
    input logic [DATA_W-1:0] cmp,
    input logic              reload,
    input logic [DATA_W-1:0] mask
  );
    if (reload && cnt == cmp) return '0;
    return (cnt + 1'b1) & mask;
  endfunction

  function automatic logic [DATA_W-1:0] tmr_ctrl_word(input logic [1:0] mode, input logic run);
    return {{(DATA_W-6){1'b0}}, mode, 3'b000, run};
  endfunction

  function automatic logic [DATA_W-1:0] tmr_clk_word(input logic src, input logic div);
    return {{(DATA_W-5){1'b0}}, src, 3'b000, div};
  endfunction

endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_fast,
  input  logic              tick_slow,
  input  logic              wr_ctrl,
  input  logic              wr_clk,
  input  logic              wr_cmp,
  input  logic              w_run,
  input  logic              w_clr,
  input  logic [1:0]        w_mode,
  input  logic              w_src,
  input  logic              w_div,
  input  logic [CNT_W-1:0]  w_cmp,
  output logic              hit_o,
  output logic [DATA_W-1:0] ctrl_rd,
  output logic [DATA_W-1:0] clk_rd,
  output logic [DATA_W-1:0] cnt_rd,
  output logic [DATA_W-1:0] cmp_rd
);

  localparam logic [DATA_W:0]   ONE_SH = (DATA_W+1)'(1) << CNT_W;
  localparam logic [DATA_W-1:0] CMASK  = ONE_SH[DATA_W-1:0] - 1'b1;

  logic             run_q, src_q, div_q, pre_q;
  tmr_mode_e        mode_q;
  logic [CNT_W-1:0] cnt_q, cmp_q;

  // Named internal events
  logic              src_tick, edge_ok, step, reload, hit;
  logic [DATA_W-1:0] cnt_nxt;

  assign src_tick = src_q ? tick_slow : tick_fast;
  assign edge_ok  = src_tick && run_q && !wr_ctrl;
  assign step     = edge_ok && (!div_q || pre_q);
  assign reload   = (mode_q == MODE_LOOP);
  assign cnt_nxt  = tmr_next(DATA_W'(cnt_q), DATA_W'(cmp_q), reload, CMASK);
  assign hit      = step && (cnt_nxt == DATA_W'(cmp_q));
  assign hit_o    = hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mode_q <= MODE_ONCE;
      pre_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (wr_ctrl) begin
      run_q  <= w_run;
      mode_q <= tmr_mode_e'(w_mode);
      if (w_clr) begin
        cnt_q <= '0;
        pre_q <= 1'b0;
      end
    end else begin
      if (edge_ok && div_q) pre_q <= !pre_q;
      if (step) cnt_q <= cnt_nxt[CNT_W-1:0];
      if (hit && mode_q == MODE_ONCE) run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= 1'b0;
      div_q <= 1'b0;
      cmp_q <= '0;
    end else begin
      if (wr_clk) begin
        src_q <= w_src;
        div_q <= w_div;
      end
      if (wr_cmp) cmp_q <= w_cmp;
    end
  end

  assign ctrl_rd = tmr_ctrl_word(mode_q, run_q);
  assign clk_rd  = tmr_clk_word(src_q, div_q);
  assign cnt_rd  = DATA_W'(cnt_q);
  assign cmp_rd  = DATA_W'(cmp_q);

  // R3: a clear write zeroes the count in the following cycle
  p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && w_clr |=> cnt_q == '0);

  // R2: without a counted tick or clear the count holds
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !(wr_ctrl && w_clr) |=> $stable(cnt_q));

  // R7: single-shot match drops the run bit
  p_once_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit && mode_q == MODE_ONCE |=> !run_q);

  // R6: auto-reload returns to zero after the compare value
  p_loop_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step && reload && cnt_q == cmp_q |=> cnt_q == '0);

  // R8: free-running always increments with wrap
  p_free_inc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step && mode_q == MODE_FREE |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int NCH = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_ie,
  input  logic           wr_ack,
  input  logic [NCH-1:0] wmask,
  input  logic [NCH-1:0] hit,
  output logic [NCH-1:0] ie_o,
  output logic [NCH-1:0] pend_o,
  output logic           irq_o
);

  logic [NCH-1:0] ie_q, pend_q, ack_bits, live;

  assign ack_bits = wr_ack ? wmask : '0;
  assign live     = pend_q & ie_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q   <= '0;
      pend_q <= '0;
    end else begin
      if (wr_ie) ie_q <= wmask;
      pend_q <= (pend_q & ~ack_bits) | hit;
    end
  end

  assign ie_o   = ie_q;
  assign pend_o = pend_q;
  assign irq_o  = |live;

  // R9: every match leaves its pending bit set
  p_hit_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    |hit |=> (pend_q & $past(hit)) == $past(hit));

  // R9: acknowledged bits without a new match are cleared
  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> (pend_q & $past(wmask & ~hit)) == '0);

  // R10: with nothing enabled the line stays low
  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ie_q == '0 |-> !irq_o);

endmodule

// File: rtl/tmr_multi.sv
module tmr_multi
  import tmr_pkg::*;
#(
  parameter int NCH    = 6,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              tick_fast,
  input  logic              tick_slow,
  output logic              irq
);

  localparam int WIN_W = ADDR_W - 4;
  localparam logic [ADDR_W-1:0] IE_ADDR  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] ACK_ADDR = ADDR_W'(8'h08);
  localparam logic [3:0] OFS_CTRL = 4'h0, OFS_CLK = 4'h4, OFS_CNT = 4'h8, OFS_CMP = 4'hC;

  logic [WIN_W-1:0] win;
  logic [3:0]       ofs;
  assign win = bus_addr[ADDR_W-1:4];
  assign ofs = bus_addr[3:0];

  logic [NCH-1:0]    hit, ie, pend;
  logic [DATA_W-1:0] ctrl_rd [NCH];
  logic [DATA_W-1:0] clk_rd  [NCH];
  logic [DATA_W-1:0] cnt_rd  [NCH];
  logic [DATA_W-1:0] cmp_rd  [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel;
    assign sel = bus_wr && (win == WIN_W'(i + 1));
    tmr_channel #(.CNT_W(CNT_W)) i_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_fast(tick_fast),
      .tick_slow(tick_slow),
      .wr_ctrl  (sel && ofs == OFS_CTRL),
      .wr_clk   (sel && ofs == OFS_CLK),
      .wr_cmp   (sel && ofs == OFS_CMP),
      .w_run    (bus_wdata[0]),
      .w_clr    (bus_wdata[1]),
      .w_mode   (bus_wdata[5:4]),
      .w_src    (bus_wdata[4]),
      .w_div    (bus_wdata[0]),
      .w_cmp    (bus_wdata[CNT_W-1:0]),
      .hit_o    (hit[i]),
      .ctrl_rd  (ctrl_rd[i]),
      .clk_rd   (clk_rd[i]),
      .cnt_rd   (cnt_rd[i]),
      .cmp_rd   (cmp_rd[i])
    );
  end

  tmr_irq #(.NCH(NCH)) i_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_ie (bus_wr && bus_addr == IE_ADDR),
    .wr_ack(bus_wr && bus_addr == ACK_ADDR),
    .wmask (bus_wdata[NCH-1:0]),
    .hit   (hit),
    .ie_o  (ie),
    .pend_o(pend),
    .irq_o (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == IE_ADDR)  bus_rdata = 32'(ie);
    if (bus_addr == ACK_ADDR) bus_rdata = 32'(pend);
    for (int i = 0; i < NCH; i++) begin
      if (win == WIN_W'(i + 1)) begin
        case (ofs)
          OFS_CTRL: bus_rdata = ctrl_rd[i];
          OFS_CLK:  bus_rdata = clk_rd[i];
          OFS_CNT:  bus_rdata = cnt_rd[i];
          OFS_CMP:  bus_rdata = cmp_rd[i];
          default:  bus_rdata = '0;
        endcase
      end
    end
  end

  // R11: the line is low in the first cycle out of reset
  p_reset_quiet_r11: assert property (@(posedge clk)
    !rst_n |=> !irq);

endmodule

// File: tb/test_tmr_multi.sv
module test_tmr_multi;

  localparam int CW = 12;
  localparam logic [31:0] MASK = (32'd1 << CW) - 1;

  logic        clk = 0, rst_n = 0;
  logic [7:0]  b_addr = 0;
  logic        b_wr = 0, b_tf = 0, b_ts = 0;
  logic [31:0] b_wdata = 0, rdata;
  logic        irq;

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  tmr_multi #(.NCH(6), .CNT_W(CW), .ADDR_W(8)) i_tmr_multi (
    .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wr(b_wr),
    .bus_wdata(b_wdata), .bus_rdata(rdata), .tick_fast(b_tf),
    .tick_slow(b_ts), .irq(irq)
  );

  // Behavioural reference model
  logic [31:0] m_cnt [6], m_cmp [6];
  bit          m_en [6], m_src [6], m_div [6], m_pre [6];
  bit [1:0]    m_mode [6];
  bit [5:0]    m_ie, m_pend;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 6; c++) begin
        m_cnt[c] = 0; m_cmp[c] = 0; m_en[c] = 0; m_src[c] = 0;
        m_div[c] = 0; m_pre[c] = 0; m_mode[c] = 0;
      end
      m_ie = 0; m_pend = 0;
    end else begin
      bit [5:0] h;
      h = 0;
      for (int c = 0; c < 6; c++) begin
        int base;
        base = 16 * (c + 1);
        if (b_wr && b_addr == base) begin
          m_en[c] = b_wdata[0]; m_mode[c] = b_wdata[5:4];
          if (b_wdata[1]) begin m_cnt[c] = 0; m_pre[c] = 0; end
        end else if (m_en[c] && (m_src[c] ? b_ts : b_tf)) begin
          bit go;
          go = !m_div[c] || m_pre[c];
          if (m_div[c]) m_pre[c] = !m_pre[c];
          if (go) begin
            if (m_mode[c] == 1 && m_cnt[c] == m_cmp[c]) m_cnt[c] = 0;
            else m_cnt[c] = (m_cnt[c] + 1) & MASK;
            if (m_cnt[c] == m_cmp[c]) begin
              h[c] = 1;
              if (m_mode[c] == 0) m_en[c] = 0;
            end
          end
        end
        if (b_wr && b_addr == base + 4) begin m_src[c] = b_wdata[4]; m_div[c] = b_wdata[0]; end
        if (b_wr && b_addr == base + 12) m_cmp[c] = b_wdata & MASK;
      end
      if (b_wr && b_addr == 8'h00) m_ie = b_wdata[5:0];
      if (b_wr && b_addr == 8'h08) m_pend = m_pend & ~b_wdata[5:0];
      m_pend = m_pend | h;
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    int c;
    if (a == 8'h00) return 32'(m_ie);
    if (a == 8'h08) return 32'(m_pend);
    c = int'(a[7:4]) - 1;
    if (c < 0 || c > 5) return 0;
    case (a[3:0])
      4'h0: return (32'(m_mode[c]) << 4) | 32'(m_en[c]);
      4'h4: return (32'(m_src[c]) << 4) | 32'(m_div[c]);
      4'h8: return m_cnt[c];
      4'hC: return m_cmp[c];
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R10: interrupt line compared with the model on every cycle
  always @(negedge clk) begin
    if (rst_n) chk("R10 irq", 32'(irq), 32'(|(m_pend & m_ie)));
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit tf = 0, input bit ts = 0);
    @(negedge clk);
    b_wr = 1; b_addr = a; b_wdata = d; b_tf = tf; b_ts = ts;
  endtask

  task automatic ticks(input int n, input bit tf, input bit ts);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      b_wr = 0; b_tf = tf; b_ts = ts;
    end
  endtask

  task automatic rd(input string tag, input logic [7:0] a);
    @(negedge clk);
    b_wr = 0; b_tf = 0; b_ts = 0; b_addr = a;
    #1;
    chk(tag, rdata, m_read(a));
  endtask

  task automatic rd_lit(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    b_wr = 0; b_tf = 0; b_ts = 0; b_addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    rd_lit("R11 ie", 8'h00, 0);
    rd_lit("R11 ack", 8'h08, 0);
    for (int c = 1; c <= 6; c++) begin
      rd_lit("R11 ctrl", 8'(16 * c), 0);
      rd_lit("R11 cnt", 8'(16 * c + 8), 0);
    end
    rd_lit("R1 unmapped", 8'h04, 0);
    // R1 readback on channel 2
    wr(8'h2C, 32'h0AB);
    wr(8'h24, 32'h11);
    wr(8'h20, 32'h33);
    rd_lit("R1 cmp", 8'h2C, 32'h0AB);
    rd_lit("R1 clksel", 8'h24, 32'h11);
    rd_lit("R3 clear reads 0", 8'h20, 32'h31);
    wr(8'h00, 32'h3F);
    rd_lit("R1 ie", 8'h00, 32'h3F);
    wr(8'h00, 32'h01);
    // R4 unselected fast ticks ignored by slow channel
    ticks(6, 1, 0);
    rd_lit("R4 fast ignored", 8'h28, 0);
    // R5 slow divided by two
    ticks(6, 0, 1);
    rd_lit("R5 div2", 8'h28, 3);
    rd("R5 model", 8'h28);
    // R2 disabled holds
    wr(8'h20, 32'h30);
    ticks(4, 0, 1);
    rd_lit("R2 hold", 8'h28, 3);
    // R7 single-shot on channel 1
    wr(8'h1C, 5);
    wr(8'h10, 32'h03);
    ticks(8, 1, 0);
    rd_lit("R7 stops at cmp", 8'h18, 5);
    rd_lit("R7 run cleared", 8'h10, 0);
    rd_lit("R9 pending", 8'h08, 32'h01);
    chk("R10 irq raised", 32'(irq), 1);
    wr(8'h08, 0);
    rd_lit("R9 ack zero no effect", 8'h08, 32'h01);
    wr(8'h08, 32'h01);
    rd_lit("R9 ack clears", 8'h08, 0);
    // R6 auto-reload on channel 4
    wr(8'h4C, 3);
    wr(8'h40, 32'h13);
    ticks(2, 1, 0);
    rd_lit("R6 cnt2", 8'h48, 2);
    ticks(1, 1, 0);
    rd_lit("R6 at cmp", 8'h48, 3);
    rd_lit("R6 pending", 8'h08, 32'h08);
    chk("R10 masked", 32'(irq), 0);
    ticks(1, 1, 0);
    rd_lit("R6 reload", 8'h48, 0);
    wr(8'h00, 32'h09);
    rd("R10 enabled", 8'h08);
    // R3 clear wins over tick
    ticks(2, 1, 0);
    wr(8'h40, 32'h13, 1, 0);
    rd_lit("R3 clear priority", 8'h48, 0);
    // R8 free-running on channel 3 with wrap
    wr(8'h3C, 32'h10);
    wr(8'h30, 32'h33);
    ticks(20, 1, 0);
    rd_lit("R8 continues", 8'h38, 20);
    rd("R8 pending", 8'h08);
    wr(8'h08, 32'h3F);
    rd("R9 ack all", 8'h08);
    ticks(4100, 1, 0);
    rd_lit("R8 wrap", 8'h38, 24);
    // R9 match wins over ack on channel 5
    wr(8'h5C, 0);
    wr(8'h50, 32'h13);
    ticks(1, 1, 0);
    wr(8'h08, 32'h10, 1, 0);
    rd("R9 set wins", 8'h08);
    chk("R9 set wins bit", rdata & 32'h10, 32'h10);
    // R8 reserved mode counts like free-running on channel 6
    wr(8'h6C, 2);
    wr(8'h60, 32'h23);
    ticks(5, 1, 0);
    rd_lit("R8 reserved", 8'h68, 5);
    rd("R8 reserved pending", 8'h08);
    for (int c = 1; c <= 6; c++) rd("R1 final cnt", 8'(16 * c + 8));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule